// File: doc/BRIEF.md
# Instruction Quadword Unpack Buffer

This block sits between instruction memory and a decode stage. Memory returns 128-bit quadwords, each as two 64-bit beats, and each quadword holds eight 16-bit halfwords. For every quadword it asked for, the request logic first pushes a short descriptor into a four-line record FIFO. The descriptor gives the position of the first wanted halfword and how many halfwords are wanted. The block takes only those halfwords, in ascending position order, and moves them into a sixteen-entry halfword queue. The decode stage drains that queue through a valid/ready handshake.

Each halfword leaves with two tags. The sequence tag and the overflow tag are both copied from the descriptor onto the first halfword unpacked from that quadword. A thermometer of five "at least k held" outputs lets the decode stage wait until a multi-halfword instruction is complete. A descriptor can be marked "same word". Such a descriptor unpacks again from the quadword already held, without any memory beats.

A flush discards everything: the record, the held quadword and the queue. After a flush, returning quadwords are dropped until one arrives carrying the priority flag.

Back-pressure: `rec_ready` is low while all record lines are occupied. `mem_ready` is low while a captured quadword waits to be unpacked, and also while a same-word descriptor is at the head of the record. `out_valid` stays high with a stable payload until `out_ready` takes it.

Top module: `iq_unpack`

## Requirements
- R1: A quadword is the accepted beat with `mem_upper`=1 followed by the next accepted beat. Halfword position p (0..7) is quadword bits [127-16p : 112-16p]. The first beat supplies bits [127:64], so bits [63:48] of the first beat are position 0.
- R2: For a descriptor with start s and count c, the block emits the halfwords at positions s, s+1, ... in order. The number emitted is n = min(c==0 ? 8 : c, 8-s). Positions never wrap past 7.
- R3: Halfwords leave in descriptor order and in position order. At most one leaves per cycle, on `out_valid && out_ready`. While `out_valid` is high and `out_ready` is low, `out_hw`, `out_seq` and `out_ovf` hold their values.
- R4: `out_seq` and `out_ovf` equal the descriptor's sequence and overflow bits on the first halfword of each descriptor, and are 0 on every other halfword.
- R5: The record holds four descriptors. With four held, `rec_full`=1 and `rec_ready`=0, and a push attempted then is ignored.
- R6: The queue holds at most sixteen halfwords. When it is full, unpacking stalls and no halfword is lost.
- R7: `held_ge[k]` is 1 exactly when at least k+1 halfwords are held (k = 0..4).
- R8: A descriptor with the same-word bit set is unpacked from the quadword captured last and consumes no memory beats.
- R9: A cycle with `flush`=1 empties the record, the queue and the held quadword. Afterwards `out_valid`=0, `held_ge`=0, `rec_full`=0 and `mem_ready`=1. A descriptor push or a pop in the flush cycle has no effect.
- R10: After a flush, quadwords whose first beat has `mem_prio`=0 are accepted and discarded. The first quadword with `mem_prio`=1 is unpacked normally and ends this dropping.
- R11: While a captured quadword waits to be unpacked or is being unpacked, `mem_ready`=0.
- R12: After reset, `out_valid`=0, `held_ge`=0, `rec_full`=0, `rec_ready`=1 and `mem_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all held state and wait for a priority quadword |
| rec_valid | input | 1 | Descriptor push request |
| rec_ready | output | 1 | Record can accept a descriptor |
| rec_start | input | 3 | First wanted halfword position |
| rec_count | input | 3 | Wanted halfword count, 0 means 8 |
| rec_oos | input | 1 | Out-of-sequence tag for the first halfword |
| rec_same | input | 1 | Reuse the quadword already captured |
| rec_ovf | input | 1 | Segment-overflow tag for the first halfword |
| rec_full | output | 1 | All record lines occupied |
| mem_valid | input | 1 | Memory beat valid |
| mem_ready | output | 1 | Memory beat accepted when valid |
| mem_upper | input | 1 | Beat is the more significant half |
| mem_prio | input | 1 | Quadword answers a priority request (first beat) |
| mem_data | input | 64 | Memory beat data |
| out_valid | output | 1 | A halfword is available |
| out_ready | input | 1 | Decode stage takes the halfword |
| out_hw | output | 16 | Halfword |
| out_seq | output | 1 | Out-of-sequence tag |
| out_ovf | output | 1 | Segment-overflow tag |
| held_ge | output | 5 | Bit k set when at least k+1 halfwords are held |

## Verification
The unpacker can write a halfword into the queue in the same cycle that the decode stage takes the oldest one. This collision shows most clearly when the queue sits at or near sixteen entries. The bench provokes it by letting the queue fill with `out_ready` held low, then releasing `out_ready` in a pseudo-random pattern while a stalled quadword is still draining in. The scoreboard judges the result: every halfword must appear exactly once, in order and with its tags, and no halfword may appear that was not predicted. A flush that lands while the record and the queue are both occupied checks that the flush takes precedence.

// File: rtl/iqu_pkg.sv
package iqu_pkg;
  localparam int HW_W    = 16;
  localparam int LANES   = 8;
  localparam int BEAT_W  = 64;
  localparam int QW_W    = HW_W * LANES;
  localparam int POS_W   = $clog2(LANES);

  typedef struct packed {
    logic [POS_W-1:0] start;
    logic [POS_W-1:0] count;
    logic             oos;
    logic             same;
    logic             ovf;
  } rec_line_t;

  typedef struct packed {
    logic [HW_W-1:0] hw;
    logic            seq;
    logic            ovf;
  } hw_item_t;
endpackage

// File: rtl/iqu_rec_fifo.sv
module iqu_rec_fifo
  import iqu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      push,
  input  rec_line_t din,
  input  logic      pop,
  output rec_line_t head,
  output logic      empty,
  output logic      full
);
  localparam int AW = $clog2(DEPTH);

  rec_line_t       lines [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     cnt;
  logic            push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = lines[rp];

  always_ff @(posedge clk) begin
    if (push_ok) lines[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  // R5
  rec_full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |=> full);
endmodule

// File: rtl/iqu_hw_queue.sv
module iqu_hw_queue
  import iqu_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  hw_item_t                   din,
  input  logic                       pop,
  output hw_item_t                   head,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  hw_item_t      slots [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count < (AW+1)'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign head    = slots[rp];

  always_ff @(posedge clk) begin
    if (push_ok) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  // R6
  hwq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < (AW+1)'(DEPTH)));

  // R3
  hwq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != '0) && !pop && !clr) |=> (head == $past(head)));
endmodule

// File: rtl/iqu_qw_capture.sv
module iqu_qw_capture
  import iqu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              accept_en,
  input  logic              mem_valid,
  input  logic              mem_upper,
  input  logic              mem_prio,
  input  logic [BEAT_W-1:0] mem_data,
  output logic              mem_ready,
  output logic [QW_W-1:0]   qw,
  output logic              qw_done
);
  logic low_phase, skip, wait_prio, beat, drop_now;

  assign mem_ready = low_phase | accept_en;
  assign beat      = mem_valid & mem_ready;
  assign drop_now  = wait_prio & ~mem_prio;
  assign qw_done   = beat & low_phase & ~skip & ~flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_phase <= 1'b0;
      skip      <= 1'b0;
      wait_prio <= 1'b0;
      qw        <= '0;
    end else if (flush) begin
      low_phase <= 1'b0;
      skip      <= 1'b0;
      wait_prio <= 1'b1;
    end else if (beat) begin
      if (!low_phase) begin
        if (mem_upper) begin
          low_phase <= 1'b1;
          skip      <= drop_now;
          if (!drop_now) qw[QW_W-1:BEAT_W] <= mem_data;
        end
      end else begin
        low_phase <= 1'b0;
        if (!skip) begin
          qw[BEAT_W-1:0] <= mem_data;
          wait_prio      <= 1'b0;
        end
      end
    end
  end

  // R10
  cap_drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !low_phase && mem_upper && drop_now && !flush)
      |=> (qw[QW_W-1:BEAT_W] == $past(qw[QW_W-1:BEAT_W])));
endmodule

// File: rtl/iq_unpack.sv
module iq_unpack
  import iqu_pkg::*;
#(
  parameter int REC_LINES   = 4,
  parameter int Q_DEPTH     = 16,
  parameter int HELD_LEVELS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   rec_valid,
  output logic                   rec_ready,
  input  logic [2:0]             rec_start,
  input  logic [2:0]             rec_count,
  input  logic                   rec_oos,
  input  logic                   rec_same,
  input  logic                   rec_ovf,
  output logic                   rec_full,
  input  logic                   mem_valid,
  output logic                   mem_ready,
  input  logic                   mem_upper,
  input  logic                   mem_prio,
  input  logic [63:0]            mem_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [15:0]            out_hw,
  output logic                   out_seq,
  output logic                   out_ovf,
  output logic [HELD_LEVELS-1:0] held_ge
);
  localparam int QCW = $clog2(Q_DEPTH) + 1;
  localparam int LW  = POS_W + 1;

  typedef enum logic {ST_IDLE, ST_UNPK} st_t;

  st_t              st;
  logic             fresh, first;
  logic [POS_W-1:0] pos;
  logic [LW-1:0]    left, cnt_eff, room, left_init;
  rec_line_t        head, din_line;
  logic             rec_empty, rec_pop, go, accept_en, qw_done;
  logic [QW_W-1:0]  qw;
  logic [HW_W-1:0]  lane [LANES];
  logic             q_push, q_pop;
  hw_item_t         q_in, q_head;
  logic [QCW-1:0]   q_count;

  assign din_line = '{start: rec_start, count: rec_count, oos: rec_oos,
                      same: rec_same, ovf: rec_ovf};

  iqu_rec_fifo #(.DEPTH(REC_LINES)) u_rec (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(rec_valid && !flush), .din(din_line), .pop(rec_pop),
    .head(head), .empty(rec_empty), .full(rec_full)
  );
  assign rec_ready = !rec_full;

  assign accept_en = (st == ST_IDLE) && !fresh && !(!rec_empty && head.same);

  iqu_qw_capture u_cap (
    .clk(clk), .rst_n(rst_n), .flush(flush), .accept_en(accept_en),
    .mem_valid(mem_valid), .mem_upper(mem_upper), .mem_prio(mem_prio),
    .mem_data(mem_data), .mem_ready(mem_ready), .qw(qw), .qw_done(qw_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = qw[QW_W-1-HW_W*g -: HW_W];
  end

  assign cnt_eff   = (head.count == '0) ? LW'(LANES) : {1'b0, head.count};
  assign room      = LW'(LANES) - {1'b0, head.start};
  assign left_init = (cnt_eff < room) ? cnt_eff : room;
  assign go        = (st == ST_IDLE) && !rec_empty && (head.same || fresh);

  assign q_push  = (st == ST_UNPK) && (q_count < QCW'(Q_DEPTH)) && !flush;
  assign rec_pop = q_push && (left == LW'(1));
  assign q_in    = '{hw: lane[pos], seq: first & head.oos, ovf: first & head.ovf};

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      st    <= ST_IDLE;
      fresh <= 1'b0;
      first <= 1'b0;
      pos   <= '0;
      left  <= '0;
    end else begin
      if (qw_done) fresh <= 1'b1;
      case (st)
        ST_IDLE: if (go) begin
          st    <= ST_UNPK;
          pos   <= head.start;
          left  <= left_init;
          first <= 1'b1;
        end
        ST_UNPK: if (q_push) begin
          pos   <= pos + 1'b1;
          left  <= left - 1'b1;
          first <= 1'b0;
          if (left == LW'(1)) begin
            st <= ST_IDLE;
            if (!head.same) fresh <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (q_count != '0);
  assign q_pop     = out_valid && out_ready && !flush;

  iqu_hw_queue #(.DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .clr(flush), .push(q_push), .din(q_in),
    .pop(q_pop), .head(q_head), .count(q_count)
  );

  assign out_hw  = q_head.hw;
  assign out_seq = q_head.seq;
  assign out_ovf = q_head.ovf;

  for (genvar k = 0; k < HELD_LEVELS; k++) begin : g_held
    assign held_ge[k] = (q_count >= QCW'(k + 1));
  end

  // R11
  fresh_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> !mem_ready);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((held_ge == '0) && !rec_full && !out_valid && mem_ready));

  // R2
  unpack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UNPK) |-> (({1'b0, pos} + {1'b0, left}) <= (LW+1)'(LANES)));
endmodule

// File: tb/iq_unpack_tb.sv
module iq_unpack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [2:0]  rec_start = '0;
  logic [2:0]  rec_count = '0;
  logic        rec_oos = 1'b0, rec_same = 1'b0, rec_ovf = 1'b0;
  logic        rec_full;
  logic        mem_valid = 1'b0;
  logic        mem_ready;
  logic        mem_upper = 1'b0, mem_prio = 1'b0;
  logic [63:0] mem_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_hw;
  logic        out_seq, out_ovf;
  logic [4:0]  held_ge;

  always #4 clk = ~clk;

  iq_unpack u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_start(rec_start),
    .rec_count(rec_count), .rec_oos(rec_oos), .rec_same(rec_same),
    .rec_ovf(rec_ovf), .rec_full(rec_full),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_upper(mem_upper),
    .mem_prio(mem_prio), .mem_data(mem_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_hw(out_hw),
    .out_seq(out_seq), .out_ovf(out_ovf), .held_ge(held_ge)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int rdy_mode = 0;
  logic [15:0]  lfsr = 16'hACE1;
  logic [17:0]  exp_q [$];
  logic [8:0]   pend_q [$];
  logic [127:0] last_qw = '0;
  bit           flushed = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [127:0] mk(input logic [15:0] base);
    logic [127:0] q;
    for (int p = 0; p < 8; p++) q[127-16*p -: 16] = base + 16'(p);
    return q;
  endfunction

  // R2 R4: predicted halfwords for one descriptor
  task automatic expand(input logic [8:0] d, input logic [127:0] q);
    int s, n;
    s = int'(d[8:6]);
    n = (d[5:3] == 3'd0) ? 8 : int'(d[5:3]);
    if (s + n > 8) n = 8 - s;
    for (int i = 0; i < n; i++)
      exp_q.push_back({q[127-16*(s+i) -: 16], (i == 0) & d[2], (i == 0) & d[0]});
  endtask

  task automatic push_desc(input logic [2:0] s, input logic [2:0] c, input bit o,
                           input bit sm, input bit v, output bit acc);
    @(posedge clk); #1;
    rec_valid = 1; rec_start = s; rec_count = c;
    rec_oos = o; rec_same = sm; rec_ovf = v;
    @(negedge clk);
    acc = rec_ready;
    @(posedge clk); #1;
    rec_valid = 0;
    if (acc) begin
      if (pend_q.size() == 0 && sm) expand({s, c, o, sm, v}, last_qw);
      else pend_q.push_back({s, c, o, sm, v});
    end
  endtask

  task automatic send_qw(input logic [127:0] q, input bit prio);
    @(posedge clk); #1;
    mem_valid = 1; mem_upper = 1; mem_prio = prio; mem_data = q[127:64];
    @(negedge clk);
    while (!mem_ready) @(negedge clk);
    @(posedge clk); #1;
    mem_upper = 0; mem_prio = 0; mem_data = q[63:0];
    @(negedge clk);
    while (!mem_ready) @(negedge clk);
    @(posedge clk); #1;
    mem_valid = 0;
    if (!(flushed && !prio)) begin
      flushed = 0;
      last_qw = q;
      if (pend_q.size() != 0) begin
        expand(pend_q.pop_front(), q);
        while (pend_q.size() != 0 && pend_q[0][1]) expand(pend_q.pop_front(), q);
      end
    end
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(out_valid == 0, req, out_valid, 0);
  endtask

  // ready driver, changes just after the rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = lfsr[0] | lfsr[3];
    endcase
  end

  // scoreboard monitor, R3 R4
  always @(negedge clk) begin
    if (rst_n && !flush && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected halfword", {14'd0, out_hw, out_seq, out_ovf}, 0);
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        check({out_hw, out_seq, out_ovf} == e, "R3/R4 halfword",
              {14'd0, out_hw, out_seq, out_ovf}, {14'd0, e});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [15:0] h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check(out_valid == 0, "R12 out_valid", out_valid, 0);
    check(held_ge == 0, "R12 held_ge", held_ge, 0);
    check(rec_full == 0 && rec_ready == 1, "R12 record", {rec_full, rec_ready}, 2'b01);
    check(mem_ready == 1, "R12 mem_ready", mem_ready, 1);

    // R1 R2: full quadword and clamped start
    rdy_mode = 1;
    push_desc(3'd0, 3'd0, 0, 0, 0, acc);
    send_qw(mk(16'h1000), 0);
    push_desc(3'd5, 3'd6, 0, 0, 0, acc);
    send_qw(mk(16'h2000), 0);
    push_desc(3'd2, 3'd3, 1, 0, 1, acc);   // R4 tags on first
    send_qw(mk(16'h3000), 0);
    drain("R2 drain");

    // R7 thermometer with ready held low
    rdy_mode = 0;
    repeat (2) @(posedge clk);
    push_desc(3'd1, 3'd3, 0, 0, 0, acc);
    send_qw(mk(16'h4000), 0);
    repeat (10) @(negedge clk);
    check(held_ge == 5'b00111, "R7 three held", held_ge, 5'b00111);
    h0 = out_hw;
    repeat (3) @(negedge clk);
    check(out_hw == h0 && out_valid, "R3 stall stable", out_hw, h0);
    push_desc(3'd6, 3'd2, 0, 0, 0, acc);
    send_qw(mk(16'h4100), 0);
    repeat (10) @(negedge clk);
    check(held_ge == 5'b11111, "R7 five held", held_ge, 5'b11111);

    // R6 R11: fill to sixteen with one quadword stalled behind
    push_desc(3'd0, 3'd0, 0, 0, 0, acc);
    send_qw(mk(16'h5000), 0);   // 13 held
    push_desc(3'd0, 3'd0, 1, 0, 0, acc);
    send_qw(mk(16'h5100), 0);   // stalls at 16
    repeat (20) @(negedge clk);
    check(held_ge == 5'b11111 && out_valid, "R6 full", held_ge, 5'b11111);
    check(mem_ready == 0, "R11 mem_ready while stalled", mem_ready, 0);
    rdy_mode = 2;                 // concurrent push and pop
    drain("R6 no loss");

    // R5 record full, extra push ignored
    rdy_mode = 1;
    push_desc(3'd0, 3'd4, 0, 0, 0, acc);
    push_desc(3'd4, 3'd4, 1, 0, 0, acc);
    push_desc(3'd7, 3'd1, 0, 0, 1, acc);
    push_desc(3'd3, 3'd0, 0, 0, 0, acc);
    @(negedge clk);
    check(rec_full == 1 && rec_ready == 0, "R5 full flags", {rec_full, rec_ready}, 2'b10);
    push_desc(3'd1, 3'd1, 1, 0, 1, acc);
    check(acc == 0, "R5 push ignored", acc, 0);
    send_qw(mk(16'h6000), 0);
    send_qw(mk(16'h6100), 0);
    send_qw(mk(16'h6200), 0);
    send_qw(mk(16'h6300), 0);
    drain("R5 drain");
    check(rec_full == 0, "R5 freed", rec_full, 0);

    // R8 same-word descriptors
    push_desc(3'd0, 3'd4, 0, 0, 0, acc);
    push_desc(3'd4, 3'd4, 1, 1, 0, acc);
    send_qw(mk(16'h7000), 0);
    drain("R8 pair");
    push_desc(3'd2, 3'd2, 0, 1, 1, acc);
    drain("R8 reuse");

    // R9 R10 flush and priority resume
    rdy_mode = 0;
    repeat (2) @(posedge clk);
    push_desc(3'd0, 3'd3, 0, 0, 0, acc);
    send_qw(mk(16'h8000), 0);
    push_desc(3'd0, 3'd0, 0, 0, 0, acc);
    repeat (8) @(negedge clk);
    @(posedge clk); #1;
    flush = 1; rec_valid = 1; rec_start = 3'd1; rec_count = 3'd1;
    rec_oos = 0; rec_same = 0; rec_ovf = 0;
    @(posedge clk); #1;
    flush = 0; rec_valid = 0;
    exp_q.delete(); pend_q.delete(); flushed = 1;
    @(negedge clk);
    check(held_ge == 0 && out_valid == 0, "R9 queue empty", held_ge, 0);
    check(rec_full == 0 && mem_ready == 1, "R9 record/mem", {rec_full, mem_ready}, 2'b01);
    push_desc(3'd1, 3'd2, 1, 0, 0, acc);
    send_qw(mk(16'h9000), 0);
    repeat (10) @(negedge clk);
    check(held_ge == 0, "R10 dropped non-priority", held_ge, 0);
    check(mem_ready == 1, "R10 mem_ready after drop", mem_ready, 1);
    send_qw(mk(16'hA000), 1);
    repeat (10) @(negedge clk);
    check(held_ge == 5'b00011, "R10 priority unpacked", held_ge, 5'b00011);
    rdy_mode = 1;
    drain("R10 drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule